// File: doc/BRIEF.md
# Elapsed Time and Event Recorder

This block measures how long a monitored input has spent asserted and counts how many separate assertion episodes have occurred. The raw input first passes a glitch filter. While the filtered level is high, a prescaler derived from the system clock produces one tick every quarter second, and each tick advances a 32-bit time counter. When the filtered level drops, a 32-bit episode counter advances by one and time accumulation stops.

Both working counters are mirrored in a simple model of nonvolatile shadow storage. Each completed episode is committed to it once, not once per tick. The working counters are reloaded from it at reset and at the start of every episode. A host can preset either counter through write strobes that stand for an already completed bus write. Such a write lands in the working copy and the shadow copy together. Two programmable limits, each with its own enable, drive an alarm pin whose active level is configurable.

Top module: `on_time_recorder`

## Requirements
- R1: A level change on `eventRaw` is acted on only if it persists for at least GLITCH_CYCLES consecutive clocks after synchronisation. A pulse shorter than that changes neither counter.
- R2: While the filtered input is high, `elapsedTime` increases by one every CLK_HZ/4 clocks. While it is low, `elapsedTime` holds.
- R3: `elapsedTime` saturates at 32'hFFFFFFFF and never wraps.
- R4: Each high-to-low transition of the filtered input adds one to `eventCount`, which saturates at 32'hFFFFFFFF.
- R5: After each falling transition, `shadowTime` and `shadowEvent` take the working values. Every shadow write holds `shadowBusy` high for exactly WRITE_CYCLES clocks.
- R6: At reset and at each rising transition of the filtered input, the working counters are loaded from the shadow copy. After reset they equal INIT_TIME and INIT_EVENT.
- R7: A pulse on `hostWrTime` (or `hostWrEvent`) writes `hostData` into both the working and the shadow copy of that counter, one clock later.
- R8: Host writes are ignored while the filtered input is high, while `shadowBusy` is high, and while a commit is pending.
- R9: The alarm condition is (`limitTimeEn` and `elapsedTime` >= `limitTime`) or (`limitEventEn` and `eventCount` >= `limitEvent`). `alarm` equals that condition when `alarmActiveHigh` is 1 and its inverse when it is 0.
- R10: The quarter-second prescaler restarts at every rising transition. The first tick of an episode therefore comes CLK_HZ/4 clocks after the filtered rise, and an episode of H filtered-high clocks adds floor(H/(CLK_HZ/4)) to `elapsedTime`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventRaw | input | 1 | Unfiltered monitored input |
| hostWrTime | input | 1 | Host strobe: preset time counter |
| hostWrEvent | input | 1 | Host strobe: preset episode counter |
| hostData | input | 32 | Value for a host preset |
| limitTime | input | 32 | Time alarm limit |
| limitEvent | input | 32 | Episode alarm limit |
| limitTimeEn | input | 1 | Enables the time limit |
| limitEventEn | input | 1 | Enables the episode limit |
| alarmActiveHigh | input | 1 | Alarm polarity, 1 = active high |
| elapsedTime | output | 32 | Working time counter (quarter seconds) |
| eventCount | output | 32 | Working episode counter |
| shadowTime | output | 32 | Shadow copy of the time counter |
| shadowEvent | output | 32 | Shadow copy of the episode counter |
| shadowBusy | output | 1 | Shadow write in progress |
| alarm | output | 1 | Alarm output |

## Verification
A raw edge reaches the filtered level 2 + GLITCH_CYCLES clocks later, and both edges see the same delay, so the filtered high time equals the raw high time. The bench therefore computes tick counts straight from raw pulse lengths and waits a fixed gap before checking the counters and the commit. Host presets appear one clock after the strobe. The busy window is counted clock by clock at falling edges. The alarm is combinational from the counters and the limits, so it is sampled one time step after a limit or polarity change.

// File: rtl/otr_pkg.sv
package otr_pkg;
  typedef struct packed {
    logic tick;
    logic load;
    logic incEvent;
    logic commit;
    logic hostTime;
    logic hostEvent;
  } strobe_t;

  localparam int unsigned COUNT_W = 32;
  localparam int unsigned TICKS_PER_SEC = 4;
endpackage

// File: rtl/otr_ctrl.sv
module otr_ctrl
  import otr_pkg::*;
#(
  parameter int unsigned GLITCH_CYCLES = 16,
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    eventRaw,
  input  logic    hostWrTime,
  input  logic    hostWrEvent,
  input  logic    shadowBusy,
  output strobe_t st
);
  localparam int unsigned GW = $clog2(GLITCH_CYCLES + 1);
  localparam int unsigned PW = $clog2(TICK_DIV);

  typedef enum logic {S_POR, S_RUN} state_t;

  logic [1:0]    syncQ;
  logic [GW-1:0] glitchCnt;
  logic          filt, filtPrev;
  logic [PW-1:0] preCnt;
  logic          commitPending;
  state_t        state;
  logic          rise, fall, hostOk;

  // two-flop synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], eventRaw};
  end

  // glitch filter: flip only after a full run of disagreeing samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      glitchCnt <= '0;
      filt      <= 1'b0;
      filtPrev  <= 1'b0;
    end else begin
      filtPrev <= filt;
      if (syncQ[1] == filt) begin
        glitchCnt <= '0;
      end else if (glitchCnt == GW'(GLITCH_CYCLES - 1)) begin
        filt      <= syncQ[1];
        glitchCnt <= '0;
      end else begin
        glitchCnt <= glitchCnt + 1'b1;
      end
    end
  end

  assign rise = filt & ~filtPrev;
  assign fall = ~filt & filtPrev;

  // quarter-second prescaler, held at zero while low so each episode restarts it
  always_ff @(posedge clk) begin
    if (!rstN || !filt)                 preCnt <= '0;
    else if (preCnt == PW'(TICK_DIV-1)) preCnt <= '0;
    else                                preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_POR;
    else       state <= S_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         commitPending <= 1'b0;
    else if (fall)     commitPending <= 1'b1;
    else if (st.commit) commitPending <= 1'b0;
  end

  assign hostOk = (state == S_RUN) & ~filt & ~fall & ~commitPending & ~shadowBusy;

  always_comb begin
    st.tick      = filt && (preCnt == PW'(TICK_DIV - 1));
    st.load      = (state == S_POR) || (rise && !commitPending);
    st.incEvent  = fall;
    st.commit    = commitPending && !shadowBusy && (state == S_RUN);
    st.hostTime  = hostOk && hostWrTime;
    st.hostEvent = hostOk && hostWrEvent && !hostWrTime;
  end

  a_r1_flip_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    (filt != $past(filt)) |-> (filt == $past(syncQ[1])));
  a_r4_fall_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> commitPending);
  a_r8_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (filt || shadowBusy) |-> !(st.hostTime || st.hostEvent));
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    st.tick |=> !st.tick);
endmodule

// File: rtl/otr_shadow.sv
module otr_shadow
  import otr_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 8,
  parameter logic [COUNT_W-1:0] INIT_TIME = '0,
  parameter logic [COUNT_W-1:0] INIT_EVENT = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrTime,
  input  logic               wrEvent,
  input  logic [COUNT_W-1:0] timeIn,
  input  logic [COUNT_W-1:0] eventIn,
  output logic [COUNT_W-1:0] timeStore,
  output logic [COUNT_W-1:0] eventStore,
  output logic               busy
);
  localparam int unsigned BW = $clog2(WRITE_CYCLES + 1);
  logic [BW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeStore  <= INIT_TIME;
      eventStore <= INIT_EVENT;
      busyCnt    <= '0;
    end else begin
      if (wrTime)  timeStore  <= timeIn;
      if (wrEvent) eventStore <= eventIn;
      if (wrTime || wrEvent)   busyCnt <= BW'(WRITE_CYCLES);
      else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrTime || wrEvent) |=> busy);
  a_r5_time_store_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrTime |=> $stable(timeStore));
endmodule

// File: rtl/otr_datapath.sv
module otr_datapath
  import otr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [COUNT_W-1:0] hostData,
  input  logic [COUNT_W-1:0] shadowTime,
  input  logic [COUNT_W-1:0] shadowEvent,
  input  logic [COUNT_W-1:0] limitTime,
  input  logic [COUNT_W-1:0] limitEvent,
  input  logic               limitTimeEn,
  input  logic               limitEventEn,
  input  logic               alarmActiveHigh,
  output logic [COUNT_W-1:0] timeReg,
  output logic [COUNT_W-1:0] eventReg,
  output logic               wrTime,
  output logic               wrEvent,
  output logic [COUNT_W-1:0] wrTimeData,
  output logic [COUNT_W-1:0] wrEventData,
  output logic               alarm
);
  localparam logic [COUNT_W-1:0] MAXV = '1;
  logic alarmCond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg  <= '0;
      eventReg <= '0;
    end else begin
      if (st.load)                          timeReg <= shadowTime;
      else if (st.hostTime)                 timeReg <= hostData;
      else if (st.tick && timeReg != MAXV)  timeReg <= timeReg + 1'b1;

      if (st.load)                              eventReg <= shadowEvent;
      else if (st.hostEvent)                    eventReg <= hostData;
      else if (st.incEvent && eventReg != MAXV) eventReg <= eventReg + 1'b1;
    end
  end

  assign wrTime      = st.commit | st.hostTime;
  assign wrEvent     = st.commit | st.hostEvent;
  assign wrTimeData  = st.hostTime  ? hostData : timeReg;
  assign wrEventData = st.hostEvent ? hostData : eventReg;

  assign alarmCond = (limitTimeEn && timeReg >= limitTime) ||
                     (limitEventEn && eventReg >= limitEvent);
  assign alarm = alarmActiveHigh ? alarmCond : ~alarmCond;

  a_r2_time_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.load && !st.hostTime) |=> $stable(timeReg));
  a_r3_time_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (timeReg == MAXV && !st.load && !st.hostTime) |=> (timeReg == MAXV));
  a_r4_event_step: assert property (@(posedge clk) disable iff (!rstN)
    (st.incEvent && !st.load && eventReg != MAXV) |=> (eventReg == $past(eventReg) + 1'b1));
  a_r9_alarm_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!limitTimeEn && !limitEventEn) |-> (alarm == !alarmActiveHigh));
endmodule

// File: rtl/on_time_recorder.sv
module on_time_recorder
  import otr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned GLITCH_CYCLES = 16,
  parameter int unsigned WRITE_CYCLES = 8,
  parameter logic [31:0] INIT_TIME = 32'h0,
  parameter logic [31:0] INIT_EVENT = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        eventRaw,
  input  logic        hostWrTime,
  input  logic        hostWrEvent,
  input  logic [31:0] hostData,
  input  logic [31:0] limitTime,
  input  logic [31:0] limitEvent,
  input  logic        limitTimeEn,
  input  logic        limitEventEn,
  input  logic        alarmActiveHigh,
  output logic [31:0] elapsedTime,
  output logic [31:0] eventCount,
  output logic [31:0] shadowTime,
  output logic [31:0] shadowEvent,
  output logic        shadowBusy,
  output logic        alarm
);
  localparam int unsigned TICK_DIV = CLK_HZ / TICKS_PER_SEC;

  strobe_t            st;
  logic               wrTime, wrEvent;
  logic [COUNT_W-1:0] wrTimeData, wrEventData;

  otr_ctrl #(.GLITCH_CYCLES(GLITCH_CYCLES), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .eventRaw(eventRaw),
    .hostWrTime(hostWrTime), .hostWrEvent(hostWrEvent),
    .shadowBusy(shadowBusy), .st(st)
  );

  otr_datapath u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .hostData(hostData),
    .shadowTime(shadowTime), .shadowEvent(shadowEvent),
    .limitTime(limitTime), .limitEvent(limitEvent),
    .limitTimeEn(limitTimeEn), .limitEventEn(limitEventEn),
    .alarmActiveHigh(alarmActiveHigh),
    .timeReg(elapsedTime), .eventReg(eventCount),
    .wrTime(wrTime), .wrEvent(wrEvent),
    .wrTimeData(wrTimeData), .wrEventData(wrEventData), .alarm(alarm)
  );

  otr_shadow #(.WRITE_CYCLES(WRITE_CYCLES), .INIT_TIME(INIT_TIME), .INIT_EVENT(INIT_EVENT)) u_shadow (
    .clk(clk), .rstN(rstN), .wrTime(wrTime), .wrEvent(wrEvent),
    .timeIn(wrTimeData), .eventIn(wrEventData),
    .timeStore(shadowTime), .eventStore(shadowEvent), .busy(shadowBusy)
  );
endmodule

// File: tb/on_time_recorder_bench.sv
module on_time_recorder_bench;
  localparam int unsigned CLK_HZ = 400;
  localparam int unsigned DIV = CLK_HZ / 4;
  localparam int unsigned GL = 4;
  localparam int unsigned WC = 6;
  localparam logic [31:0] IT = 32'h10;
  localparam logic [31:0] IE = 32'h3;
  localparam int unsigned GAP = 60;

  typedef struct packed {
    logic [31:0] hiCycles;
    logic [31:0] ticks;
    logic [31:0] events;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd250, 32'd2, 32'd1},
    '{32'd3,   32'd0, 32'd0},
    '{32'd30,  32'd0, 32'd1},
    '{32'd150, 32'd1, 32'd1},
    '{32'd420, 32'd4, 32'd1},
    '{32'd2,   32'd0, 32'd0}
  };

  logic clk = 1'b0, rstN = 1'b0, eventRaw = 1'b0;
  logic hostWrTime = 1'b0, hostWrEvent = 1'b0;
  logic [31:0] hostData = '0, limitTime = '0, limitEvent = '0;
  logic limitTimeEn = 1'b0, limitEventEn = 1'b0, alarmActiveHigh = 1'b1;
  logic [31:0] elapsedTime, eventCount, shadowTime, shadowEvent;
  logic shadowBusy, alarm;

  int nChecks = 0, nFails = 0;
  logic [31:0] expTime, expEvent;
  bit done = 1'b0;

  always #4 clk = ~clk;

  on_time_recorder #(.CLK_HZ(CLK_HZ), .GLITCH_CYCLES(GL), .WRITE_CYCLES(WC),
                     .INIT_TIME(IT), .INIT_EVENT(IE)) u_on_time_recorder (
    .clk(clk), .rstN(rstN), .eventRaw(eventRaw),
    .hostWrTime(hostWrTime), .hostWrEvent(hostWrEvent), .hostData(hostData),
    .limitTime(limitTime), .limitEvent(limitEvent),
    .limitTimeEn(limitTimeEn), .limitEventEn(limitEventEn),
    .alarmActiveHigh(alarmActiveHigh),
    .elapsedTime(elapsedTime), .eventCount(eventCount),
    .shadowTime(shadowTime), .shadowEvent(shadowEvent),
    .shadowBusy(shadowBusy), .alarm(alarm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int unsigned hi);
    @(negedge clk) eventRaw = 1'b1;
    repeat (hi) @(negedge clk);
    eventRaw = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic hostWrite(input bit toTime, input logic [31:0] v);
    @(negedge clk);
    hostData = v;
    if (toTime) hostWrTime = 1'b1; else hostWrEvent = 1'b1;
    @(negedge clk);
    hostWrTime = 1'b0;
    hostWrEvent = 1'b0;
  endtask

  task automatic checkCounters(input string req);
    check({req, " time"}, elapsedTime, expTime);
    check({req, " event"}, eventCount, expEvent);
    check({req, " shadow time"}, shadowTime, expTime);
    check({req, " shadow event"}, shadowEvent, expEvent);
  endtask

  initial begin
    int busyLen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    expTime = IT;
    expEvent = IE;
    // R6: power-on load from shadow
    checkCounters("R6 reset");
    check("R9 reset alarm idle", {31'b0, alarm}, 32'd0);

    // R1 R2 R4 R5 R10: vector walk
    foreach (VECS[i]) begin
      pulse(VECS[i].hiCycles);
      expTime += VECS[i].ticks;
      expEvent += VECS[i].events;
      checkCounters($sformatf("R2/R4/R5/R10/R1 vector %0d", i));
    end

    // R9: alarm compares and polarity
    limitTime = expTime; limitTimeEn = 1'b1; #1;
    check("R9 time equal", {31'b0, alarm}, 32'd1);
    limitTime = expTime + 1; #1;
    check("R9 time below", {31'b0, alarm}, 32'd0);
    alarmActiveHigh = 1'b0; #1;
    check("R9 polarity low", {31'b0, alarm}, 32'd1);
    limitEvent = expEvent; limitEventEn = 1'b1; #1;
    check("R9 event equal low pol", {31'b0, alarm}, 32'd0);
    limitTime = expTime - 1; limitEventEn = 1'b0; alarmActiveHigh = 1'b1; #1;
    check("R9 time above", {31'b0, alarm}, 32'd1);
    limitTimeEn = 1'b0; #1;
    check("R9 disabled", {31'b0, alarm}, 32'd0);

    // R8: host write while high is ignored
    @(negedge clk) eventRaw = 1'b1;
    repeat (20) @(negedge clk);
    hostWrite(1'b1, 32'h5);
    repeat (2) @(negedge clk);
    check("R8 write while high time", elapsedTime, expTime);
    check("R8 write while high shadow", shadowTime, expTime);
    eventRaw = 1'b0;
    expEvent += 1;
    repeat (GAP) @(negedge clk);
    checkCounters("R4 short episode");

    // R7: host preset of time; R5 busy length
    hostWrite(1'b1, 32'hFFFF_FFFE);
    busyLen = 0;
    while (shadowBusy && busyLen < 100) begin
      busyLen++;
      @(negedge clk);
    end
    expTime = 32'hFFFF_FFFE;
    check("R5 busy length", busyLen, WC);
    check("R7 time preset", elapsedTime, expTime);
    check("R7 shadow time preset", shadowTime, expTime);

    // R8: second write during busy is ignored
    @(negedge clk);
    hostData = 32'h7; hostWrEvent = 1'b1;
    @(negedge clk);
    hostWrEvent = 1'b0; hostData = 32'h0; hostWrTime = 1'b1;
    @(negedge clk);
    hostWrTime = 1'b0;
    repeat (GAP) @(negedge clk);
    expEvent = 32'h7;
    checkCounters("R8/R7 write during busy");

    // R3: saturation of time
    pulse(350);
    expTime = 32'hFFFF_FFFF;
    expEvent += 1;
    checkCounters("R3 time saturation");

    // R4: saturation of event count
    hostWrite(1'b0, 32'hFFFF_FFFF);
    repeat (GAP) @(negedge clk);
    pulse(50);
    expEvent = 32'hFFFF_FFFF;
    checkCounters("R4 event saturation");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule